// File: doc/BRIEF.md
# Multi-Channel RC Servo Pulse Generator

This block drives a bank of hobby servo outputs from a single frame counter. Every channel starts its pulse at the same frame boundary. Each channel then stays high for its own programmed number of clock ticks. On a 50 MHz clock one tick is 20 ns, so the standard 20 ms frame is a period value of 1,000,000. The channel count is a build-time parameter and defaults to 8.

A host reaches the block through a simple register port. The port has one address, a write strobe with write data, and a combinational read path. Behind the port sit the following registers:

- a shared period register;
- one on-time register per channel;
- a configuration register with one enable bit per channel and a global enable bit.

The host can read the configuration register back, so it can set or clear a single channel with a read-modify-write. Period and on-time writes are held as pending values. A running frame picks them up only at its wrap, so a running output never produces a shortened or stretched pulse.

Top module: `servo_bank`

## Requirements
- R1: After reset every output is low. The period register reads 1,000,000 (the default), and the configuration and on-time registers read 0.
- R2: Register map at byte-free word addresses:
  - Address 0 is the period, held in the low 20 bits.
  - Address 1 is the configuration. Bit n enables channel n, and bit 31 is the global enable.
  - Address 2+n is the on-time of channel n, held in the low 20 bits.
  - Reads return the stored value, and bits that are not stored read 0.
- R3: A write to any address outside 0 to 2+N-1 changes no register. A read from such an address returns 0.
- R4: While running, a frame lasts `period` ticks. A channel whose on-time is T is high for the first T ticks of each frame and low for the rest.
- R5: An on-time of 0 gives a constant low output. An on-time at or above the period gives a constant high output.
- R6: An output is low in every cycle in which its channel bit or the global bit is clear. This takes effect in the cycle right after the configuration write.
- R7: The frame counter runs from 0 to period-1 and then wraps to 0. A period of 0 or 1 holds it at 0. While the global bit is clear the counter is held at 0.
- R8: Period and on-time writes made while running take effect only at the next frame start.
- R9: While the global bit is clear, period and on-time writes take effect at once. The first frame after enabling therefore uses them, starting at count 0.
- R10: All channels share one frame, so every enabled pulse rises in the same cycle, at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |
| servoOut | output | 8 | One pulse output per channel |

## Verification
On every cycle the assertions check the following:
- the gating by channel and global enables;
- that the frame counter stays below the active period and sits at 0 while stopped;
- that active period and on-time values change only at count 0;
- that no output is high at or past its on-time;
- that a pulse on an enabled channel can rise only at count 0.

Other behaviours can only be shown by the bench's directed scenarios:
- the exact pulse widths and frame lengths;
- the register map and its truncation;
- that writes to unmapped addresses are ignored;
- the difference between writes made while stopped and writes made mid-frame.

The bench observes these at the ports against a cycle model built from the requirements.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int IDX_W       = 8;
  localparam int ADDR_PERIOD = 0;
  localparam int ADDR_CONFIG = 1;
  localparam int ADDR_ON_BASE = 2;

  typedef struct packed {
    logic             perWe;
    logic             cfgWe;
    logic             onWe;
    logic [IDX_W-1:0] onIdx;
  } servo_strobe_t;
endpackage

// File: rtl/servo_ctrl.sv
module servo_ctrl
  import servo_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [CNT_W-1:0]              shPeriod,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shOn,
  input  logic [NUM_CH-1:0]             cfgEn,
  input  logic                          cfgGlobal,
  output servo_strobe_t                 strobe,
  output logic [DATA_W-1:0]             regRdData
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(ADDR_PERIOD);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADDR_CONFIG);
  localparam logic [ADDR_W-1:0] A_ONB = ADDR_W'(ADDR_ON_BASE);
  localparam logic [ADDR_W-1:0] A_NCH = ADDR_W'(NUM_CH);

  logic [ADDR_W-1:0] onOff;
  logic              onHit;

  assign onOff = regAddr - A_ONB;
  assign onHit = (regAddr >= A_ONB) && (onOff < A_NCH);

  always_comb begin
    strobe       = '0;
    strobe.perWe = regWrEn && (regAddr == A_PER);
    strobe.cfgWe = regWrEn && (regAddr == A_CFG);
    strobe.onWe  = regWrEn && onHit;
    strobe.onIdx = IDX_W'(onOff);
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == A_PER) begin
      regRdData[CNT_W-1:0] = shPeriod;
    end else if (regAddr == A_CFG) begin
      regRdData[NUM_CH-1:0] = cfgEn;
      regRdData[DATA_W-1]   = cfgGlobal;
    end else if (onHit) begin
      regRdData[CNT_W-1:0] = shOn[onOff[SEL_W-1:0]];
    end
  end
endmodule

// File: rtl/servo_dp.sv
module servo_dp
  import servo_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 20,
  parameter int DEF_PERIOD = 1000000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  servo_strobe_t                 strobe,
  input  logic [DATA_W-1:0]             wrData,
  output logic [CNT_W-1:0]              shPeriod,
  output logic [NUM_CH-1:0][CNT_W-1:0]  shOn,
  output logic [NUM_CH-1:0]             cfgEn,
  output logic                          cfgGlobal,
  output logic [CNT_W-1:0]              frameCnt,
  output logic [CNT_W-1:0]              actPeriod,
  output logic [NUM_CH-1:0][CNT_W-1:0]  actOn,
  output logic [NUM_CH-1:0]             servoOut
);
  localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_PERIOD);

  logic frameEnd;
  logic unusedWr;

  assign unusedWr = ^wrData;

  // Pending (host-visible) registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPeriod  <= RST_PERIOD;
      cfgEn     <= '0;
      cfgGlobal <= 1'b0;
    end else begin
      if (strobe.perWe) shPeriod <= wrData[CNT_W-1:0];
      if (strobe.cfgWe) begin
        cfgEn     <= wrData[NUM_CH-1:0];
        cfgGlobal <= wrData[DATA_W-1];
      end
    end
  end

  // Shared frame counter; active copies reload at wrap or while stopped
  assign frameEnd = (frameCnt + CNT_W'(1)) >= actPeriod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt  <= '0;
      actPeriod <= RST_PERIOD;
    end else if (!cfgGlobal || frameEnd) begin
      frameCnt  <= '0;
      actPeriod <= shPeriod;
    end else begin
      frameCnt  <= frameCnt + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shOn[i]  <= '0;
        actOn[i] <= '0;
      end else begin
        if (strobe.onWe && (strobe.onIdx == IDX_W'(i))) shOn[i] <= wrData[CNT_W-1:0];
        if (!cfgGlobal || frameEnd) actOn[i] <= shOn[i];
      end
    end
    assign servoOut[i] = cfgGlobal & cfgEn[i] & (frameCnt < actOn[i]);
  end
endmodule

// File: rtl/servo_bank.sv
module servo_bank
  import servo_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 20,
  parameter int DEF_PERIOD = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] servoOut
);
  servo_strobe_t                strobe;
  logic [CNT_W-1:0]             shPeriod;
  logic [NUM_CH-1:0][CNT_W-1:0] shOn;
  logic [NUM_CH-1:0]            cfgEn;
  logic                         cfgGlobal;
  logic [CNT_W-1:0]             frameCnt;
  logic [CNT_W-1:0]             actPeriod;
  logic [NUM_CH-1:0][CNT_W-1:0] actOn;

  servo_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .shPeriod  (shPeriod),
    .shOn      (shOn),
    .cfgEn     (cfgEn),
    .cfgGlobal (cfgGlobal),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  servo_dp #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .shPeriod  (shPeriod),
    .shOn      (shOn),
    .cfgEn     (cfgEn),
    .cfgGlobal (cfgGlobal),
    .frameCnt  (frameCnt),
    .actPeriod (actPeriod),
    .actOn     (actOn),
    .servoOut  (servoOut)
  );
endmodule

// File: rtl/servo_bank_chk.sv
module servo_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 20
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CH-1:0]            servoOut,
  input logic [NUM_CH-1:0]            cfgEn,
  input logic                         cfgGlobal,
  input logic [CNT_W-1:0]             frameCnt,
  input logic [CNT_W-1:0]             actPeriod,
  input logic [NUM_CH-1:0][CNT_W-1:0] actOn
);
  assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgGlobal |-> (servoOut == '0));

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameCnt == '0) || (frameCnt < actPeriod));

  assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgGlobal |=> (frameCnt == '0));

  assert_period_at_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actPeriod) |-> (frameCnt == '0));

  assert_ontime_at_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actOn) |-> (frameCnt == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_ch_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
      !cfgEn[i] |-> !servoOut[i]);

    assert_width_R4: assert property (@(posedge clk) disable iff (!rstN)
      (frameCnt >= actOn[i]) |-> !servoOut[i]);

    assert_rise_at_start_R10: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(servoOut[i]) && $past(cfgGlobal && cfgEn[i])) |-> (frameCnt == '0));
  end
endmodule

bind servo_bank servo_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .servoOut  (servoOut),
  .cfgEn     (cfgEn),
  .cfgGlobal (cfgGlobal),
  .frameCnt  (frameCnt),
  .actPeriod (actPeriod),
  .actOn     (actOn)
);

// File: tb/servo_bank_tb.sv
module servo_bank_tb_top;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 20;
  localparam int DEF_PERIOD = 1000000;
  localparam int MASK = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [NUM_CH-1:0] servoOut;

  int checks = 0;
  int errors = 0;

  // Reference model state, derived from the requirements
  int          mCnt, mActPer, mShPer;
  int          mActOn [NUM_CH];
  int          mShOn  [NUM_CH];
  logic        mGlob;
  logic [NUM_CH-1:0] mEn;

  always #4 clk = ~clk;

  servo_bank dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .servoOut(servoOut)
  );

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [NUM_CH-1:0] expOut();
    logic [NUM_CH-1:0] e;
    for (int i = 0; i < NUM_CH; i++) e[i] = mGlob && mEn[i] && (mCnt < mActOn[i]);
    return e;
  endfunction

  task automatic modelWrite(input int a, input logic [31:0] d);
    if (a == 0) mShPer = int'(d) & MASK;
    else if (a == 1) begin mGlob = d[31]; mEn = d[NUM_CH-1:0]; end
    else if (a >= 2 && a < 2 + NUM_CH) mShOn[a-2] = int'(d) & MASK;
  endtask

  task automatic checkOut(input string tag);
    logic [NUM_CH-1:0] e;
    e = expOut();
    checks++;
    if (servoOut !== e) begin
      errors++;
      $display("FAIL %s: servoOut=%b expected %b (count %0d)", tag, servoOut, e, mCnt);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (!mGlob || (mCnt + 1 >= mActPer)) begin
      mCnt = 0; mActPer = mShPer;
      for (int i = 0; i < NUM_CH; i++) mActOn[i] = mShOn[i];
    end else mCnt++;
    if (regWrEn) modelWrite(int'(regAddr), regWrData);
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic runFor(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic regWrite(input int a, input logic [31:0] d, input string tag);
    regAddr = 8'(a); regWrData = d; regWrEn = 1'b1;
    tick(tag);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input int a, input logic [31:0] e, input string tag);
    regAddr = 8'(a);
    #1;
    checks++;
    if (regRdData !== e) begin
      errors++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, regRdData, e);
    end
  endtask

  task automatic testReset();
    checkOut("R1");
    readCheck(0, 32'(DEF_PERIOD), "R1");
    readCheck(1, 32'h0, "R1");
    for (int i = 0; i < NUM_CH; i++) readCheck(2 + i, 32'h0, "R1");
  endtask

  task automatic testMap();
    regWrite(0, 32'hFFF0_0010, "R2");
    readCheck(0, 32'h0000_0010, "R2");
    regWrite(1, 32'h7FFF_FF05, "R2");
    readCheck(1, 32'h0000_0005, "R2");
    regWrite(7, 32'hABC1_2345, "R2");
    readCheck(7, 32'h0001_2345, "R2");
    regWrite(1, 32'hFFFF_FFFF, "R2");
    readCheck(1, 32'h8000_00FF, "R2");
    regWrite(1, 32'h0000_0005, "R2");
  endtask

  task automatic testUnmapped();
    regWrite(10, 32'hFFFF_FFFF, "R3");
    regWrite(200, 32'hFFFF_FFFF, "R3");
    readCheck(10, 32'h0, "R3");
    readCheck(200, 32'h0, "R3");
    readCheck(0, 32'h0000_0010, "R3");
    readCheck(1, 32'h0000_0005, "R3");
    readCheck(7, 32'h0001_2345, "R3");
    readCheck(9, 32'h0, "R3");
  endtask

  task automatic testPulse();
    regWrite(0, 32'd10, "R4");
    regWrite(2, 32'd3, "R4");
    regWrite(3, 32'd0, "R5");
    regWrite(4, 32'd10, "R5");
    regWrite(5, 32'd7, "R4");
    regWrite(6, 32'd1, "R4");
    regWrite(7, 32'd0, "R5");
    regWrite(1, 32'h8000_001F, "R10");
    runFor(35, "R4 R5 R10");
  endtask

  task automatic testGate();
    regWrite(1, 32'h8000_001E, "R6");
    runFor(6, "R6");
    regWrite(1, 32'h0000_001F, "R6");
    runFor(4, "R6");
  endtask

  task automatic testStopped();
    regWrite(0, 32'd6, "R9");
    regWrite(2, 32'd2, "R9");
    regWrite(1, 32'h8000_0001, "R9");
    runFor(20, "R9 R7");
  endtask

  task automatic testMidFrame();
    runFor(3, "R8");
    regWrite(0, 32'd9, "R8");
    regWrite(2, 32'd5, "R8");
    runFor(30, "R8");
  endtask

  task automatic testShortPeriod();
    regWrite(0, 32'd1, "R7");
    runFor(10, "R7");
    regWrite(0, 32'd0, "R7");
    runFor(6, "R7");
    regWrite(0, 32'd4, "R7");
    runFor(12, "R7");
  endtask

  initial begin
    mCnt = 0; mActPer = DEF_PERIOD; mShPer = DEF_PERIOD;
    mGlob = 1'b0; mEn = '0;
    for (int i = 0; i < NUM_CH; i++) begin mActOn[i] = 0; mShOn[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMap();
    testUnmapped();
    testPulse();
    testGate();
    testStopped();
    testMidFrame();
    testShortPeriod();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule